// File: doc/BRIEF.md
# Granule Tag Check Unit

This block decides whether a memory access may proceed by comparing the 4-bit tag carried in the pointer (address bits 59:56) against the allocation tag stored for every 16-byte granule the access covers. The stored tags come from an external tag store through a read port with a combinational return path. Each byte of that store holds two granule tags, one per nibble. The unit walks the covered granules at one tag byte per clock, so it checks up to two granules per cycle. It stops at the first mismatch.

A request is a single-cycle `start_i` pulse. It carries the address, the access length minus one, a per-half top-byte enable pair and a match-all enable. When the top byte is not in use, or the pointer tag is the match-all value, the request finishes without reading tags and reports unchecked. Otherwise the result is pass or fail. On fail, a fault address names where the failing granule begins, as seen from the direction of the walk. A reverse mode suits copies that run downward. In that mode the address names the last byte of the access and the walk runs toward lower granules.

Top module: `granule_tag_check`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pass_o`, `fail_o`, `unchecked_o`, `tag_rd_o` and `fault_addr_o` are all zero.
- R2: Address bit 55 picks the half: `tbi_en_i[0]` applies when bit 55 is 0, and `tbi_en_i[1]` applies when bit 55 is 1. If the selected enable is 0, the request completes unchecked, with `done_o` and `unchecked_o` high on the cycle after the start edge, and no tag is read.
- R3: The request also completes unchecked in one cycle when `tcm_en_i` is 1 and the pointer tag (bits 59:56) equals 4'h0 with bit 55 = 0, or 4'hF with bit 55 = 1.
- R4: In forward mode the granules checked run from addr>>4 to (addr+size_m1)>>4 inclusive. If every stored tag equals the pointer tag, the result is pass.
- R5: The tag for granule index g sits in tag byte g>>1, driven on `tag_addr_o` as address bits [TAG_AW+4:5]. Address bit 4 = 0 selects the low nibble (bits 3:0) and bit 4 = 1 selects the high nibble (bits 7:4).
- R6: One tag byte is read per busy cycle. `done_o` rises N clock edges after the start edge, where N is the number of distinct tag bytes visited up to and including the stop granule, and N is at least 1. `busy_o` and `done_o` are never high together.
- R7: Forward fail: when the first granule mismatches, `fault_addr_o` is the access start address. When a later granule g mismatches, `fault_addr_o` is g*16.
- R8: Reverse mode (`rev_i`=1): the address names the last byte, and the granules run from addr>>4 down to (addr-size_m1)>>4. Within a byte the high nibble is checked before the low one. A fail on the first granule reports the start address. A fail on a later granule g reports g*16+15.
- R9: Checking stops at the first mismatching granule in walk order. Later mismatches change neither the fault address nor the latency.
- R10: `start_i` is ignored while `busy_o` is high. It does not change the running check's result.
- R11: When `done_o` is high, exactly one of `pass_o`, `fail_o`, `unchecked_o` is high. The flags hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| addr_i | input | 64 | Access address with pointer tag in bits 59:56 |
| size_m1_i | input | SIZE_W | Access length in bytes minus one |
| tbi_en_i | input | 2 | Top-byte enable per half, indexed by address bit 55 |
| tcm_en_i | input | 1 | Enables the match-all tag bypass |
| rev_i | input | 1 | Reverse walk; address is the last byte |
| tag_rd_o | output | 1 | Tag read strobe |
| tag_addr_o | output | TAG_AW | Tag byte address |
| tag_data_i | input | 8 | Tag byte, two granule tags, same-cycle return |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | All checked tags matched |
| fail_o | output | 1 | A tag mismatched |
| unchecked_o | output | 1 | Check bypassed |
| fault_addr_o | output | 64 | Fault address, valid with fail_o |

## Verification
The assertions assume that `tag_data_i` settles in the same cycle as `tag_addr_o` and belongs to that address. They also assume that `size_m1_i` never exceeds the SIZE_W range, so at most 17 granules are covered. The bench meets the first assumption with a combinational array lookup. It meets the second by drawing lengths only from the 8-bit range. The bench also pulses `start_i` during a running walk, to exercise the ignore rule rather than relying on the source to stay idle.

// File: rtl/gtc_pkg.sv
// Shared definitions for the granule tag check unit.
// Assumes a 16-byte granule and a 4-bit tag in address bits 59:56.
package gtc_pkg;
    localparam int GRAN_LOG2 = 4;
    localparam int GIDX_W    = 64 - GRAN_LOG2;

    // Outcome of comparing one tag byte against the pointer tag.
    typedef struct packed {
        logic miss0;  // first nibble in walk order differs
        logic miss1;  // second nibble differs (meaningful only with two)
        logic two;    // second nibble belongs to the access
    } nib_cmp_t;
endpackage

// File: rtl/gtc_bypass.sv
// Decides whether a request skips tag checking.
// Assumes the address half is selected by bit 55 and that the match-all
// tag is all zeros for the lower half and all ones for the upper half.
module gtc_bypass (
    input  logic [63:0] addr_i,
    input  logic [1:0]  tbi_en_i,
    input  logic        tcm_en_i,
    output logic        skip_o
);
    logic       half;
    logic [3:0] ptag;

    // Flags an unchecked access from the top-byte and match-all rules.
    always_comb begin
        half   = addr_i[55];
        ptag   = addr_i[59:56];
        skip_o = !tbi_en_i[half] || (tcm_en_i && (ptag == {4{half}}));
    end
endmodule

// File: rtl/gtc_span.sv
// Derives the starting granule index and the number of granules covered.
// Assumes size_m1 is small enough that the span fits CNT_W bits.
module gtc_span #(
    parameter int SIZE_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [63:0]                 addr_i,
    input  logic [SIZE_W-1:0]           size_m1_i,
    input  logic                        rev_i,
    output logic [gtc_pkg::GIDX_W-1:0]  g0_o,
    output logic [CNT_W-1:0]            count_o
);
    import gtc_pkg::*;

    logic [63:0]       far_addr;
    logic [GIDX_W-1:0] g_far;
    logic [GIDX_W-1:0] diff;

    // Computes the far end of the access and the inclusive granule count.
    always_comb begin
        far_addr = rev_i ? (addr_i - 64'(size_m1_i)) : (addr_i + 64'(size_m1_i));
        g0_o     = addr_i[63:GRAN_LOG2];
        g_far    = far_addr[63:GRAN_LOG2];
        diff     = rev_i ? (g0_o - g_far) : (g_far - g0_o);
        count_o  = diff[CNT_W-1:0] + CNT_W'(1);
    end
endmodule

// File: rtl/gtc_nibble_cmp.sv
// Compares the one or two granule tags held in a tag byte with the pointer tag.
// Assumes the walk's current granule index parity picks the first nibble:
// odd -> high nibble, even -> low nibble, in both walk directions.
module gtc_nibble_cmp (
    input  logic [7:0]        byte_i,
    input  logic [3:0]        tag_i,
    input  logic              odd_i,
    input  logic              rev_i,
    input  logic              more_i,
    output gtc_pkg::nib_cmp_t res_o
);
    logic [3:0] first_nib;
    logic [3:0] second_nib;

    // Orders the nibbles along the walk and flags mismatches.
    always_comb begin
        first_nib   = odd_i ? byte_i[7:4] : byte_i[3:0];
        second_nib  = odd_i ? byte_i[3:0] : byte_i[7:4];
        res_o.two   = more_i && (rev_i ? odd_i : !odd_i);
        res_o.miss0 = (first_nib != tag_i);
        res_o.miss1 = (second_nib != tag_i);
    end
endmodule

// File: rtl/granule_tag_check.sv
// Granule tag check unit: walks the tag bytes of an access one byte per
// cycle and reports pass, fail with fault address, or unchecked.
// Assumes tag_data_i answers tag_addr_o within the same cycle.
module granule_tag_check #(
    parameter int SIZE_W = 8,
    parameter int TAG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [63:0]       addr_i,
    input  logic [SIZE_W-1:0] size_m1_i,
    input  logic [1:0]        tbi_en_i,
    input  logic              tcm_en_i,
    input  logic              rev_i,
    output logic              tag_rd_o,
    output logic [TAG_AW-1:0] tag_addr_o,
    input  logic [7:0]        tag_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              unchecked_o,
    output logic [63:0]       fault_addr_o
);
    import gtc_pkg::*;

    localparam int MAX_GRAN = ((1 << SIZE_W) >> GRAN_LOG2) + 1;
    localparam int CNT_W    = $clog2(MAX_GRAN + 1);

    logic              skip;
    logic [GIDX_W-1:0] g0;
    logic [CNT_W-1:0]  count;
    nib_cmp_t          cmp;

    logic              busy_q, done_q, pass_q, fail_q, skip_q, rev_q, first_q;
    logic [3:0]        tag_q;
    logic [GIDX_W-1:0] gran_q;
    logic [CNT_W-1:0]  left_q;
    logic [63:0]       start_q, fault_q;

    logic [CNT_W-1:0]  take;
    logic [GIDX_W-1:0] gran_next, gran_second;
    logic [63:0]       fault_first, fault_second;

    gtc_bypass u_bypass (
        .addr_i   (addr_i),
        .tbi_en_i (tbi_en_i),
        .tcm_en_i (tcm_en_i),
        .skip_o   (skip)
    );

    gtc_span #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_span (
        .addr_i    (addr_i),
        .size_m1_i (size_m1_i),
        .rev_i     (rev_i),
        .g0_o      (g0),
        .count_o   (count)
    );

    gtc_nibble_cmp u_cmp (
        .byte_i (tag_data_i),
        .tag_i  (tag_q),
        .odd_i  (gran_q[0]),
        .rev_i  (rev_q),
        .more_i (left_q >= CNT_W'(2)),
        .res_o  (cmp)
    );

    // Steps the walk and forms the fault address for either nibble.
    always_comb begin
        take         = cmp.two ? CNT_W'(2) : CNT_W'(1);
        gran_next    = rev_q ? (gran_q - GIDX_W'(take)) : (gran_q + GIDX_W'(take));
        gran_second  = rev_q ? (gran_q - GIDX_W'(1)) : (gran_q + GIDX_W'(1));
        fault_first  = first_q ? start_q
                     : (rev_q ? {gran_q, 4'hF} : {gran_q, 4'h0});
        fault_second = rev_q ? {gran_second, 4'hF} : {gran_second, 4'h0};
    end

    // Accepts requests when idle and walks the tag bytes while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            skip_q  <= 1'b0;
            rev_q   <= 1'b0;
            first_q <= 1'b0;
            tag_q   <= '0;
            gran_q  <= '0;
            left_q  <= '0;
            start_q <= '0;
            fault_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    pass_q  <= 1'b0;
                    fail_q  <= 1'b0;
                    fault_q <= '0;
                    start_q <= addr_i;
                    tag_q   <= addr_i[59:56];
                    rev_q   <= rev_i;
                    gran_q  <= g0;
                    left_q  <= count;
                    first_q <= 1'b1;
                    skip_q  <= skip;
                    done_q  <= skip;
                    busy_q  <= !skip;
                end
            end else begin
                first_q <= 1'b0;
                if (cmp.miss0) begin
                    fail_q  <= 1'b1;
                    fault_q <= fault_first;
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                end else if (cmp.two && cmp.miss1) begin
                    fail_q  <= 1'b1;
                    fault_q <= fault_second;
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                end else if (left_q <= take) begin
                    pass_q  <= 1'b1;
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                end else begin
                    gran_q  <= gran_next;
                    left_q  <= left_q - take;
                end
            end
        end
    end

    assign tag_rd_o     = busy_q;
    assign tag_addr_o   = gran_q[TAG_AW:1];
    assign busy_o       = busy_q;
    assign done_o       = done_q;
    assign pass_o       = pass_q;
    assign fail_o       = fail_q;
    assign unchecked_o  = skip_q;
    assign fault_addr_o = fault_q;

    // Exactly one outcome flag accompanies completion.
    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({pass_o, fail_o, unchecked_o}) == 1));

    // Completion and an active walk never overlap.
    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // A walk only ends through a completion strobe.
    assert_busy_ends_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // A bypassed request finishes on the next edge as unchecked.
    assert_skip_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && skip) |=> (done_o && unchecked_o));

    // A running walk always has granules left to check.
    assert_left_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (left_q != '0));

    // A fault address is the start address or a granule edge in walk direction.
    assert_fault_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> ((fault_addr_o == start_q) ||
                                (fault_addr_o[3:0] == (rev_q ? 4'hF : 4'h0))));
endmodule

// File: tb/granule_tag_check_tb.sv
// Bench: behavioural model of latency and result, compared every cycle.
module granule_tag_check_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_AW     = 12;
    localparam int SIZE_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [63:0]       addr_i = '0;
    logic [SIZE_W-1:0] size_m1_i = '0;
    logic [1:0]        tbi_en_i = 2'b11;
    logic              tcm_en_i = 1'b0;
    logic              rev_i = 1'b0;
    logic              tag_rd_o;
    logic [TAG_AW-1:0] tag_addr_o;
    logic [7:0]        tag_data_i;
    logic              busy_o, done_o, pass_o, fail_o, unchecked_o;
    logic [63:0]       fault_addr_o;

    logic [7:0] mem [0:(1<<TAG_AW)-1];
    assign tag_data_i = mem[tag_addr_o];

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    granule_tag_check #(.SIZE_W(SIZE_W), .TAG_AW(TAG_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .size_m1_i(size_m1_i), .tbi_en_i(tbi_en_i), .tcm_en_i(tcm_en_i),
        .rev_i(rev_i), .tag_rd_o(tag_rd_o), .tag_addr_o(tag_addr_o),
        .tag_data_i(tag_data_i), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .unchecked_o(unchecked_o),
        .fault_addr_o(fault_addr_o)
    );

    task automatic check64(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] nib(input logic [59:0] g);
        logic [7:0] b;
        b = mem[g[TAG_AW:1]];
        return g[0] ? b[7:4] : b[3:0];
    endfunction

    // Reference: result 0 pass, 1 fail, 2 unchecked; latency in edges.
    task automatic model_calc(input logic [63:0] a, input int sz, input logic [1:0] tbi,
                              input logic tcm, input logic rv, output int lat,
                              output int res, output logic [63:0] flt);
        logic        b55;
        logic [3:0]  pt;
        logic [59:0] g0, gend, gs;
        int          k, fail_at;
        b55 = a[55];
        pt  = a[59:56];
        flt = '0;
        if (!tbi[b55] || (tcm && pt == {4{b55}})) begin
            lat = 1;
            res = 2;
            return;
        end
        g0   = a[63:4];
        gend = rv ? 60'((a - 64'(sz)) >> 4) : 60'((a + 64'(sz)) >> 4);
        k    = rv ? int'(g0 - gend) + 1 : int'(gend - g0) + 1;
        fail_at = -1;
        for (int i = 0; i < k; i++) begin
            if (nib(rv ? g0 - 60'(i) : g0 + 60'(i)) != pt) begin
                fail_at = i;
                break;
            end
        end
        gs  = (fail_at >= 0) ? (rv ? g0 - 60'(fail_at) : g0 + 60'(fail_at)) : gend;
        lat = rv ? int'((g0 >> 1) - (gs >> 1)) + 1 : int'((gs >> 1) - (g0 >> 1)) + 1;
        res = (fail_at >= 0) ? 1 : 0;
        if (fail_at == 0) flt = a;
        else if (fail_at > 0) flt = rv ? {gs, 4'hF} : {gs, 4'h0};
    endtask

    logic        exp_busy = 1'b0, exp_done = 1'b0;
    int          exp_left = 0, exp_res = 0;
    logic [63:0] exp_flt = '0;

    // Model state advances on each rising edge from the bench-driven inputs.
    always @(posedge clk) begin
        int lat, res;
        logic [63:0] flt;
        if (!rst_n) begin
            exp_busy = 1'b0;
            exp_done = 1'b0;
            exp_left = 0;
        end else begin
            exp_done = 1'b0;
            if (exp_busy) begin
                exp_left--;
                if (exp_left == 0) begin
                    exp_busy = 1'b0;
                    exp_done = 1'b1;
                end
            end else if (start_i) begin
                model_calc(addr_i, int'(size_m1_i), tbi_en_i, tcm_en_i, rev_i, lat, res, flt);
                exp_res = res;
                exp_flt = flt;
                if (res == 2) exp_done = 1'b1;
                else begin
                    exp_busy = 1'b1;
                    exp_left = lat;
                end
            end
        end
    end

    // Comparison on the falling edge, every cycle out of reset.
    always @(negedge clk) begin
        if (rst_n) begin
            check64("busy (R6)", 64'(busy_o), 64'(exp_busy));
            check64("done (R6)", 64'(done_o), 64'(exp_done));
            if (exp_done) begin
                check64("pass (R11)", 64'(pass_o), 64'(exp_res == 0));
                check64("fail (R11)", 64'(fail_o), 64'(exp_res == 1));
                check64("unchecked (R11)", 64'(unchecked_o), 64'(exp_res == 2));
                if (exp_res == 1) check64("fault address", fault_addr_o, exp_flt);
            end
        end
    end

    function automatic logic [63:0] mk(input logic [3:0] tag, input logic b55, input logic [54:0] low);
        return {4'h0, tag, b55, low};
    endfunction

    task automatic fill(input logic [3:0] t);
        for (int i = 0; i < (1 << TAG_AW); i++) mem[i] = {t, t};
    endtask

    task automatic poke(input logic [59:0] g, input logic [3:0] t);
        if (g[0]) mem[g[TAG_AW:1]][7:4] = t;
        else      mem[g[TAG_AW:1]][3:0] = t;
    endtask

    task automatic run(input string req, input logic [63:0] a, input int sz,
                       input logic [1:0] tbi, input logic tcm, input logic rv);
        cur_req   = req;
        @(negedge clk);
        addr_i    = a;
        size_m1_i = SIZE_W'(sz);
        tbi_en_i  = tbi;
        tcm_en_i  = tcm;
        rev_i     = rv;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        fill(4'h5);
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held
        check64("reset busy/done/flags R1",
                {58'd0, busy_o, done_o, pass_o, fail_o, unchecked_o, tag_rd_o}, 64'd0);
        check64("reset fault R1", fault_addr_o, 64'd0);
        rst_n = 1'b1;

        // R2: top-byte disabled for the selected half
        run("R2", mk(4'h5, 1'b0, 55'h100), 15, 2'b10, 1'b0, 1'b0);
        run("R2", mk(4'h5, 1'b1, 55'h100), 15, 2'b01, 1'b0, 1'b0);
        fill(4'h9);
        run("R2", mk(4'h5, 1'b1, 55'h100), 15, 2'b10, 1'b0, 1'b0); // checked, fails
        // R3: match-all tags
        fill(4'h0);
        run("R3", mk(4'h0, 1'b0, 55'h200), 31, 2'b11, 1'b1, 1'b0);
        run("R3", mk(4'hF, 1'b1, 55'h200), 31, 2'b11, 1'b1, 1'b0);
        run("R3", mk(4'h0, 1'b0, 55'h200), 31, 2'b11, 1'b0, 1'b0); // checked, passes
        // R4 / R5: forward passes with several alignments
        fill(4'h5);
        run("R4", mk(4'h5, 1'b0, 55'h300), 15, 2'b11, 1'b0, 1'b0);
        run("R5", mk(4'h5, 1'b0, 55'h314), 3, 2'b11, 1'b0, 1'b0);
        run("R4", mk(4'h5, 1'b0, 55'h400), 255, 2'b11, 1'b0, 1'b0);
        run("R6", mk(4'h5, 1'b0, 55'h108), 255, 2'b11, 1'b0, 1'b0);
        run("R6", mk(4'h5, 1'b0, 55'h118), 255, 2'b11, 1'b0, 1'b0);
        // R5: low versus high nibble of one byte
        poke(60'h31, 4'h2);
        run("R5", mk(4'h5, 1'b0, 55'h300), 15, 2'b11, 1'b0, 1'b0);
        run("R5", mk(4'h5, 1'b0, 55'h318), 7, 2'b11, 1'b0, 1'b0);
        // R7: fault on first granule and on later ones
        run("R7", mk(4'h5, 1'b0, 55'h31C), 40, 2'b11, 1'b0, 1'b0);
        run("R7", mk(4'h5, 1'b0, 55'h305), 40, 2'b11, 1'b0, 1'b0);
        fill(4'h5);
        poke(60'h46, 4'h1);
        run("R7", mk(4'h5, 1'b0, 55'h40A), 200, 2'b11, 1'b0, 1'b0);
        // R9: a second mismatch later does not change the outcome
        poke(60'h49, 4'h3);
        run("R9", mk(4'h5, 1'b0, 55'h40A), 200, 2'b11, 1'b0, 1'b0);
        // R8: reverse walks
        fill(4'h5);
        run("R8", mk(4'h5, 1'b0, 55'h6FF), 255, 2'b11, 1'b0, 1'b1);
        run("R8", mk(4'h5, 1'b0, 55'h6EF), 100, 2'b11, 1'b0, 1'b1);
        poke(60'h6E, 4'h7);
        run("R8", mk(4'h5, 1'b0, 55'h6E3), 30, 2'b11, 1'b0, 1'b1);
        run("R8", mk(4'h5, 1'b0, 55'h6F7), 60, 2'b11, 1'b0, 1'b1);
        poke(60'h6B, 4'h8);
        run("R9", mk(4'h5, 1'b0, 55'h6FF), 255, 2'b11, 1'b0, 1'b1);
        // R10: start pulse during a walk is ignored
        fill(4'h5);
        poke(60'h88, 4'hC);
        cur_req = "R10";
        @(negedge clk);
        addr_i = mk(4'h5, 1'b0, 55'h800); size_m1_i = 8'd200;
        tbi_en_i = 2'b11; tcm_en_i = 1'b0; rev_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        addr_i = mk(4'h5, 1'b0, 55'h900); tbi_en_i = 2'b00; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        check64("ignored start keeps fault R10", fault_addr_o, mk(4'h5, 1'b0, 55'h880));
        check64("ignored start keeps fail R10", 64'(fail_o), 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule